// File: doc/BRIEF.md
# Register-Programmable Watchdog Timer

A byte-wide, register-mapped watchdog for a system controller. Software starts and stops the count with a run bit, restarts it with a ping bit, programs the timeout, and reads back the time that remains. When the count runs out, the primary instance requests a system reset and records the cause in a sticky flag. An auxiliary instance instead raises a one-cycle alarm and keeps counting.

A `VERSION` parameter picks the timeout encoding. Version 1 holds a power-of-two exponent of milliseconds. Version 2 holds 8-bit whole seconds. Version 3 holds 16-bit seconds spread over two adjacent byte registers. A two-stage prescaler turns the system clock into millisecond and second ticks. The host bridge sits outside the block and drives a plain write strobe and read strobe.

Register addresses (3-bit): 0 control, 1 cause, 2 timeout low byte, 3 timeout high byte, 4 time-left low byte, 5 time-left high byte. All other addresses read 0.

Top module: `sysctl_wdt`

## Requirements
- R1: After rst_n is low at a clock edge: rst_req and alarm are 0, the run bit and the cause flag are 0, the time-left registers read 0, and the timeout low byte reads INIT_TMO (default 10).
- R2: With VERSION 1, a write to address 2 stores only bits [3:0] as an exponent n. Bits [7:4] are ignored and read 0. The period is 2^max(n,10) ms, so the shortest period is 1024 ms and the longest is 32768 ms.
- R3: With VERSION 2, address 2 holds 8-bit seconds. A programmed 0 counts as 1 second. Address 3 and address 5 read 0.
- R4: With VERSION 3, the 16-bit timeout is split with the low byte at address 2 and the high byte at address 3. A programmed 0 counts as 1 second.
- R5: A read returns data one clock after the read strobe. For versions 2 and 3, address 4 returns the low byte of the remaining count in seconds. For version 3, address 5 returns the high byte captured at the last read of address 4. For version 1, both addresses read 0.
- R6: Bit 0 of address 0 is the run bit, and every write to address 0 sets it from data bit 0. A 0-to-1 change loads the effective timeout and clears the prescaler. Writing 1 while running does not reload. Writing 0 freezes the count.
- R7: Writing 1 to bit 1 of address 0 (ping) reloads the counter and clears the prescaler. Ping reads back as 0.
- R8: A timeout write does not change a count already in progress. The new value is used at the next load.
- R9: The count decrements once per unit U. U is CLKS_PER_MS clocks for version 1 and CLKS_PER_MS*MS_PER_SEC clocks otherwise. On a primary instance (IS_MAIN=1), rst_req rises exactly T*U clocks after the load edge and stays high for PULSE_CYC (16) cycles. At that same edge, cause bit 0 at address 1 is set and the run bit is cleared.
- R10: On an auxiliary instance (IS_MAIN=0), expiry gives a one-cycle alarm pulse and reloads the count, so alarms repeat every T*U clocks. rst_req stays 0 and the cause flag stays 0.
- R11: The cause flag is cleared only by rst_n or by writing 1 to bit 0 of address 1. Writing 0 there has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (3) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid one clock after bus_re |
| rst_req | output | 1 | System reset request (primary instance) |
| alarm | output | 1 | One-cycle expiry pulse (auxiliary instance) |

## Verification
Every load (start or ping) is taken at one recorded clock edge. Expiry is due exactly T*U edges after that edge. The reset pulse ends 16 edges after it rises. A time-left read reflects every unit boundary that falls strictly before the read edge. The bench records the edge number of each write and read from a free-running edge counter, then samples outputs at the falling clock edge just before and just after each due edge. It therefore confirms both that nothing happens early and that the result arrives on time. Register reads are compared one clock after the strobe.

// File: rtl/wdt_pkg.sv
// Package: shared widths, register addresses and timeout decoding for the watchdog.
// Assumes a byte-wide data bus and a 16-bit internal count.
package wdt_pkg;
    localparam int BUS_W      = 8;
    localparam int ADDR_W     = 3;
    localparam int TMO_W      = 16;
    localparam int V1_EXP_W   = 4;
    localparam int V1_EXP_MIN = 10;
    localparam int RUN_BIT    = 0;
    localparam int PING_BIT   = 1;
    localparam int CAUSE_BIT  = 0;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 3'd0,
        REG_CAUSE   = 3'd1,
        REG_TMO_LO  = 3'd2,
        REG_TMO_HI  = 3'd3,
        REG_LEFT_LO = 3'd4,
        REG_LEFT_HI = 3'd5
    } wdt_reg_e;

    // Turn a stored timeout into the count to load, in units of the selected tick.
    function automatic logic [TMO_W-1:0] effective_timeout(input int version,
                                                           input logic [TMO_W-1:0] raw);
        logic [V1_EXP_W-1:0] expo;
        logic [TMO_W-1:0]    res;
        expo = raw[V1_EXP_W-1:0];
        if (version == 1) begin
            if (expo < V1_EXP_W'(V1_EXP_MIN))
                expo = V1_EXP_W'(V1_EXP_MIN);
            res = TMO_W'(1) << expo;
        end else if (version == 2) begin
            res = (raw[BUS_W-1:0] == '0) ? TMO_W'(1) : TMO_W'(raw[BUS_W-1:0]);
        end else begin
            res = (raw == '0) ? TMO_W'(1) : raw;
        end
        return res;
    endfunction
endpackage

// File: rtl/wdt_tick_gen.sv
// Prescaler: divides the clock into millisecond ticks, and optionally into second ticks.
// Assumes CLKS_PER_MS >= 2 and MS_PER_SEC >= 2. A clear restarts both stages so the
// first interval after a load is a full one.
module wdt_tick_gen #(
    parameter int CLKS_PER_MS = 125000,
    parameter int MS_PER_SEC  = 1000,
    parameter bit SEC_UNIT    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int MS_W = $clog2(CLKS_PER_MS);

    logic [MS_W-1:0] ms_cnt;
    logic            ms_tick;

    assign ms_tick = (ms_cnt == MS_W'(CLKS_PER_MS - 1));

    // Clock divider for the millisecond stage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ms_cnt <= '0;
        else if (ms_tick)
            ms_cnt <= '0;
        else
            ms_cnt <= ms_cnt + MS_W'(1);
    end

    generate
        if (SEC_UNIT) begin : g_sec
            localparam int SEC_W = $clog2(MS_PER_SEC);
            logic [SEC_W-1:0] sec_cnt;
            logic             sec_last;
            assign sec_last = (sec_cnt == SEC_W'(MS_PER_SEC - 1));

            // Millisecond-tick divider for the second stage.
            always_ff @(posedge clk) begin
                if (!rst_n || clr)
                    sec_cnt <= '0;
                else if (ms_tick)
                    sec_cnt <= sec_last ? '0 : sec_cnt + SEC_W'(1);
            end
            assign tick = ms_tick && sec_last;
        end else begin : g_ms
            assign tick = ms_tick;
        end
    endgenerate
endmodule

// File: rtl/wdt_countdown.sv
// Down-counter and expiry outputs. It loads the effective timeout and decrements once
// per tick while running. At the step from 1 it fires: a primary instance stops at 0
// and stretches a reset request, an auxiliary instance reloads and pulses an alarm.
module wdt_countdown
    import wdt_pkg::*;
#(
    parameter bit IS_MAIN   = 1'b1,
    parameter int PULSE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic             tick,
    input  logic [TMO_W-1:0] tmo_eff,
    output logic [TMO_W-1:0] cnt,
    output logic             fire,
    output logic             rst_req,
    output logic             alarm
);
    assign fire = run && tick && !load && (cnt == TMO_W'(1));

    // Main count register: load, decrement, or end-of-count handling.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= tmo_eff;
        else if (run && tick) begin
            if (cnt == TMO_W'(1))
                cnt <= IS_MAIN ? '0 : tmo_eff;
            else
                cnt <= cnt - TMO_W'(1);
        end
    end

    generate
        if (IS_MAIN) begin : g_main
            localparam int PW = $clog2(PULSE_CYC + 1);
            logic [PW-1:0] pulse_left;

            // Stretch the expiry event into a fixed-length reset request.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pulse_left <= '0;
                else if (fire)
                    pulse_left <= PW'(PULSE_CYC);
                else if (pulse_left != '0)
                    pulse_left <= pulse_left - PW'(1);
            end
            assign rst_req = (pulse_left != '0);
            assign alarm   = 1'b0;
        end else begin : g_aux
            logic alarm_q;

            // Register the expiry event as a single-cycle alarm.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    alarm_q <= 1'b0;
                else
                    alarm_q <= fire;
            end
            assign alarm   = alarm_q;
            assign rst_req = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/wdt_regs.sv
// Register decode: run bit, ping trigger, timeout storage per encoding version,
// sticky cause flag, time-left readback with high-byte capture, registered read data.
// Assumes single-cycle write and read strobes from a host bridge.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int VERSION  = 2,
    parameter bit IS_MAIN  = 1'b1,
    parameter int INIT_TMO = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [TMO_W-1:0]  cnt,
    input  logic              fire,
    output logic              run,
    output logic              load,
    output logic              cause,
    output logic [TMO_W-1:0]  tmo_eff,
    output logic [BUS_W-1:0]  rdata
);
    logic             wr_ctrl, wr_cause, wr_lo, wr_hi, rd_left_lo, expire_main;
    logic [TMO_W-1:0] tmo_q;
    logic [BUS_W-1:0] left_hi_q;
    logic [BUS_W-1:0] rd_mux;

    assign wr_ctrl     = we && (addr == REG_CTRL);
    assign wr_cause    = we && (addr == REG_CAUSE);
    assign wr_lo       = we && (addr == REG_TMO_LO);
    assign wr_hi       = we && (addr == REG_TMO_HI);
    assign rd_left_lo  = re && (addr == REG_LEFT_LO);
    assign expire_main = IS_MAIN && fire;
    assign load        = wr_ctrl && ((wdata[RUN_BIT] && !run) || wdata[PING_BIT]);
    assign tmo_eff     = effective_timeout(VERSION, tmo_q);

    // Run bit: follows control writes, dropped by a primary expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= 1'b0;
        else if (wr_ctrl)
            run <= wdata[RUN_BIT];
        else if (expire_main)
            run <= 1'b0;
    end

    // Sticky cause flag: set on primary expiry, cleared by write-1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cause <= 1'b0;
        else if (expire_main)
            cause <= 1'b1;
        else if (wr_cause && wdata[CAUSE_BIT])
            cause <= 1'b0;
    end

    generate
        if (VERSION == 1) begin : g_v1
            // Exponent field only; the other bits of the byte are not stored.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tmo_q <= TMO_W'(INIT_TMO) & TMO_W'((1 << V1_EXP_W) - 1);
                else if (wr_lo)
                    tmo_q <= TMO_W'(wdata[V1_EXP_W-1:0]);
            end
        end else if (VERSION == 2) begin : g_v2
            // Single byte of whole seconds.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tmo_q <= TMO_W'(INIT_TMO) & TMO_W'((1 << BUS_W) - 1);
                else if (wr_lo)
                    tmo_q <= TMO_W'(wdata);
            end
        end else begin : g_v3
            // Two byte lanes of a 16-bit seconds value.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tmo_q <= TMO_W'(INIT_TMO);
                else begin
                    if (wr_lo) tmo_q[BUS_W-1:0]     <= wdata;
                    if (wr_hi) tmo_q[TMO_W-1:BUS_W] <= wdata;
                end
            end
        end
    endgenerate

    // Capture the upper count byte when the lower one is read, for a coherent pair.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_hi_q <= '0;
        else if (rd_left_lo)
            left_hi_q <= cnt[TMO_W-1:BUS_W];
    end

    // Read multiplexer over the register map.
    always_comb begin
        rd_mux = '0;
        case (addr)
            REG_CTRL:    rd_mux[RUN_BIT]   = run;
            REG_CAUSE:   rd_mux[CAUSE_BIT] = cause;
            REG_TMO_LO:  rd_mux = tmo_q[BUS_W-1:0];
            REG_TMO_HI:  rd_mux = (VERSION == 3) ? tmo_q[TMO_W-1:BUS_W] : '0;
            REG_LEFT_LO: rd_mux = (VERSION == 1) ? '0 : cnt[BUS_W-1:0];
            REG_LEFT_HI: rd_mux = (VERSION == 3) ? left_hi_q : '0;
            default:     rd_mux = '0;
        endcase
    end

    // Registered read data, updated on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (re)
            rdata <= rd_mux;
    end
endmodule

// File: rtl/sysctl_wdt.sv
// Top level of the register-programmable watchdog: ties the register block,
// prescaler and down-counter together. VERSION picks the timeout encoding,
// IS_MAIN picks reset-request or alarm-only behaviour at expiry.
module sysctl_wdt
    import wdt_pkg::*;
#(
    parameter int VERSION     = 2,
    parameter bit IS_MAIN     = 1'b1,
    parameter int CLKS_PER_MS = 125000,
    parameter int MS_PER_SEC  = 1000,
    parameter int PULSE_CYC   = 16,
    parameter int INIT_TMO    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              rst_req,
    output logic              alarm
);
    localparam bit SEC_UNIT = (VERSION != 1);

    logic             run_w, load_w, tick_w, fire_w, cause_w;
    logic [TMO_W-1:0] cnt_w, tmo_eff_w;

    wdt_regs #(.VERSION(VERSION), .IS_MAIN(IS_MAIN), .INIT_TMO(INIT_TMO)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .re(bus_re), .addr(bus_addr),
        .wdata(bus_wdata), .cnt(cnt_w), .fire(fire_w), .run(run_w), .load(load_w),
        .cause(cause_w), .tmo_eff(tmo_eff_w), .rdata(bus_rdata)
    );

    wdt_tick_gen #(.CLKS_PER_MS(CLKS_PER_MS), .MS_PER_SEC(MS_PER_SEC),
                   .SEC_UNIT(SEC_UNIT)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(load_w), .tick(tick_w)
    );

    wdt_countdown #(.IS_MAIN(IS_MAIN), .PULSE_CYC(PULSE_CYC)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run_w), .load(load_w), .tick(tick_w),
        .tmo_eff(tmo_eff_w), .cnt(cnt_w), .fire(fire_w), .rst_req(rst_req), .alarm(alarm)
    );
endmodule

// File: rtl/wdt_checker.sv
// Checker bound to sysctl_wdt: temporal properties of the count, cause flag and outputs.
// Assumes the prescaled unit is at least two clocks long.
module wdt_checker
    import wdt_pkg::*;
#(
    parameter bit IS_MAIN   = 1'b1,
    parameter int PULSE_CYC = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic              run,
    input logic              load,
    input logic [TMO_W-1:0]  cnt,
    input logic              cause,
    input logic              rst_req,
    input logic              alarm
);
    localparam int HW = $clog2(PULSE_CYC + 2);
    logic [HW-1:0] hi_cnt;

    // Length of the current reset-request run, in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (rst_req)
            hi_cnt <= hi_cnt + HW'(1);
        else
            hi_cnt <= '0;
    end

    a_r11_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cause && !(bus_we && bus_addr == REG_CAUSE && bus_wdata[CAUSE_BIT]) |=> cause);

    a_r6_frozen_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !load |=> $stable(cnt));

    a_r6_running_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt != '0);

    a_r10_alarm_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> !alarm);

    generate
        if (IS_MAIN) begin : g_main_chk
            a_r9_cause_with_request: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_req) |-> cause);
            a_r9_request_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_req) |-> !run);
            a_r9_pulse_not_longer: assert property (@(posedge clk) disable iff (!rst_n)
                rst_req |-> hi_cnt < HW'(PULSE_CYC));
            a_r9_pulse_full_length: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(rst_req) |-> hi_cnt == HW'(PULSE_CYC));
        end
    endgenerate
endmodule

bind sysctl_wdt wdt_checker #(.IS_MAIN(IS_MAIN), .PULSE_CYC(PULSE_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .run(run_w), .load(load_w), .cnt(cnt_w), .cause(cause_w), .rst_req(rst_req), .alarm(alarm)
);

// File: tb/sim_sysctl_wdt.sv
// Bench: three instances (v3 primary, v2 auxiliary, v1 primary) on a shared bus.
module sim_sysctl_wdt;
    localparam int CPM = 2;
    localparam int MPS = 4;
    localparam int U_SEC = CPM * MPS;
    localparam int U_MS = CPM;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_we = '0;
    logic       bus_re = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] rd0, rd1, rd2;
    logic       rq0, rq1, rq2, al0, al1, al2;
    int         cyc = 0;
    int         nchk = 0;
    int         nerr = 0;
    int         last_edge;
    int         rd_val;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sysctl_wdt #(.VERSION(3), .IS_MAIN(1'b1), .CLKS_PER_MS(CPM), .MS_PER_SEC(MPS)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we[0]), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd0), .rst_req(rq0), .alarm(al0));
    sysctl_wdt #(.VERSION(2), .IS_MAIN(1'b0), .CLKS_PER_MS(CPM), .MS_PER_SEC(MPS)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we[1]), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd1), .rst_req(rq1), .alarm(al1));
    sysctl_wdt #(.VERSION(1), .IS_MAIN(1'b1), .CLKS_PER_MS(CPM), .MS_PER_SEC(MPS)) u2 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we[2]), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd2), .rst_req(rq2), .alarm(al2));

    // Expected count left at a read edge, given load edge and unit.
    function automatic int left_at(int t, int unit, int e0, int edge_no);
        return t - ((edge_no - 1 - e0) / unit);
    endfunction

    // Expected period in clocks for a v1 exponent.
    function automatic int v1_period(int expo);
        int e = expo & 15;
        if (e < 10) e = 10;
        return (1 << e) * U_MS;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        nchk++;
        if (got != exp) begin
            nerr++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input int inst, input int a, input int d);
        bus_addr = 3'(a);
        bus_wdata = 8'(d);
        bus_we[inst] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = '0;
        last_edge = cyc;
    endtask

    task automatic rd(input int inst, input int a);
        bus_addr = 3'(a);
        bus_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
        last_edge = cyc;
        rd_val = (inst == 0) ? int'(rd0) : (inst == 1) ? int'(rd1) : int'(rd2);
    endtask

    task automatic wait_until(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    function automatic int rq_of(int inst);
        return (inst == 0) ? int'(rq0) : int'(rq2);
    endfunction

    // Expiry of a primary instance: not early, on time, full pulse, then low.
    task automatic expect_main(input int inst, input int e0, input int period, input string req);
        wait_until(e0 + period - 1);
        chk({req, " no early reset"}, rq_of(inst), 0);
        wait_until(e0 + period);
        chk({req, " reset on time"}, rq_of(inst), 1);
        wait_until(e0 + period + 15);
        chk("R9 pulse still high at cycle 16", rq_of(inst), 1);
        wait_until(e0 + period + 16);
        chk("R9 pulse ends after 16", rq_of(inst), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: got 0 expected 1 (run finished)");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int e0, t, stop_e, frozen;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rst_req", int'(rq0), 0);
        chk("R1 alarm", int'(al1), 0);
        rd(0, 0); chk("R1 run bit", rd_val, 0);
        rd(0, 1); chk("R1 cause", rd_val, 0);
        rd(0, 2); chk("R1 timeout default", rd_val, 10);
        rd(0, 4); chk("R1 time left", rd_val, 0);

        // R4 / R5: 16-bit timeout split, time-left pair
        wr(0, 2, 8'h2C); wr(0, 3, 8'h01);
        rd(0, 2); chk("R4 timeout lo", rd_val, 8'h2C);
        rd(0, 3); chk("R4 timeout hi", rd_val, 8'h01);
        wr(0, 0, 1); e0 = last_edge;
        rd(0, 4); chk("R5 left lo", rd_val, left_at(300, U_SEC, e0, last_edge) & 255);
        rd(0, 5); chk("R5 left hi captured", rd_val, 1);
        wait_until(e0 + 10);
        rd(0, 4); chk("R5 left after one unit", rd_val, left_at(300, U_SEC, e0, last_edge) & 255);
        // R6 stop freezes the count
        wr(0, 0, 0); stop_e = last_edge;
        frozen = 300 - ((stop_e - e0) / U_SEC);
        wait_until(stop_e + 30);
        rd(0, 4); chk("R6 frozen when stopped", rd_val, frozen & 255);
        rd(0, 0); chk("R6 run bit cleared", rd_val, 0);

        // R4 zero counts as one second; R9 cause; R11 write-1-to-clear
        wr(0, 2, 0); wr(0, 3, 0);
        wr(0, 0, 1); e0 = last_edge;
        expect_main(0, e0, U_SEC, "R4 zero timeout");
        rd(0, 1); chk("R9 cause set", rd_val, 1);
        rd(0, 0); chk("R9 run cleared", rd_val, 0);
        wr(0, 1, 0); rd(0, 1); chk("R11 write 0 keeps cause", rd_val, 1);
        wr(0, 1, 1); rd(0, 1); chk("R11 write 1 clears cause", rd_val, 0);

        // R8 timeout change mid-count has no effect until next load
        wr(0, 2, 3); wr(0, 0, 1); e0 = last_edge;
        wait_until(e0 + 5);
        wr(0, 2, 1);
        expect_main(0, e0, 3 * U_SEC, "R8 old timeout kept");
        wr(0, 1, 1);

        // R7 ping reloads; R6 rewriting run=1 does not
        wr(0, 2, 2); wr(0, 0, 1); e0 = last_edge;
        wait_until(e0 + 10);
        wr(0, 0, 3); t = last_edge;
        rd(0, 0); chk("R7 ping reads 0", rd_val, 1);
        expect_main(0, t, 2 * U_SEC, "R7 ping reload");
        wr(0, 0, 1); e0 = last_edge;
        wait_until(e0 + 10);
        wr(0, 0, 1);
        expect_main(0, e0, 2 * U_SEC, "R6 no reload while running");
        wr(0, 1, 1);

        // R9 random timeouts on the primary v3 instance
        for (int i = 0; i < 6; i++) begin
            t = 1 + int'($urandom % 5);
            wr(0, 2, t); wr(0, 3, 0);
            wr(0, 0, 1); e0 = last_edge;
            expect_main(0, e0, t * U_SEC, "R9 random expiry");
            rd(0, 1); chk("R9 random cause", rd_val, 1);
            wr(0, 1, 1);
        end

        // R3 / R10 auxiliary v2 instance
        rd(1, 2); chk("R3 default seconds", rd_val, 10);
        wr(1, 2, 200); rd(1, 2); chk("R3 byte readback", rd_val, 200);
        rd(1, 3); chk("R3 hi timeout reads 0", rd_val, 0);
        wr(1, 2, 0); wr(1, 0, 1); e0 = last_edge;
        wait_until(e0 + U_SEC - 1); chk("R10 no early alarm", int'(al1), 0);
        wait_until(e0 + U_SEC);     chk("R10 alarm on time (R3 zero as 1)", int'(al1), 1);
        wait_until(e0 + U_SEC + 1); chk("R10 alarm one cycle", int'(al1), 0);
        wait_until(e0 + 2 * U_SEC); chk("R10 alarm repeats", int'(al1), 1);
        chk("R10 no reset request", int'(rq1), 0);
        rd(1, 1); chk("R10 cause stays 0", rd_val, 0);
        rd(1, 4); rd(1, 5); chk("R5 v2 left hi reads 0", rd_val, 0);
        wr(1, 0, 0);

        // R2 v1 exponent encoding
        wr(2, 2, 8'hFB); rd(2, 2); chk("R2 upper bits ignored", rd_val, 8'h0B);
        rd(2, 4); chk("R5 v1 left reads 0", rd_val, 0);
        wr(2, 2, 3); wr(2, 0, 1); e0 = last_edge;
        expect_main(2, e0, v1_period(3), "R2 exponent clamped to 10");
        wr(2, 2, 11); wr(2, 0, 1); e0 = last_edge;
        expect_main(2, e0, v1_period(11), "R2 exponent 11");
        rd(2, 1); chk("R9 v1 cause", rd_val, 1);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule